// File: doc/BRIEF.md
# External Memory Chip-Select Decoder

This block turns a 22-bit external bus address into active-low chip selects for two families of memory devices. The first family holds code and is reached by instruction fetches and table reads. The second holds data and is reached by data-move accesses. Four code selects divide the address space into four equal banks. The bank size is chosen at run time by a 3-bit size field and ranges from 32 KB to 1 MB per select.

Four data selects cover the same four banks. Each one only reaches its pin when a 3-bit pin-assignment field hands that pin over from general-purpose I/O. A 4-bit merge mask lets a code device also answer data accesses, so that one device (for example a flash holding the program) can be read as code and rewritten through data writes. For a merged bank a data read is steered to the code read strobe and a data write to the write strobe.

All selects and strobes are registered. They show the decode of the address and strobes presented on the previous clock edge. The three configuration fields load synchronously from their own write ports.

Top module: `xmem_cs_decode`

## Requirements
- R1: With size code `c` (bits [2:0]), the bank size S is 2^15 bytes when c[2]=0 (codes 000 to 011) and 2^(17+c[1:0]) bytes when c[2]=1 (100=128 KB, 101=256 KB, 110=512 KB, 111=1 MB). For an address in [n*S, (n+1)*S), n in 0..3, a code access (`acc_data`=0) drives `prog_ce_n[n]` low and every other code select high.
- R2: An address at or above 4*S drives no select low, and at most one bit of `prog_ce_n` is low in any cycle.
- R3: Reset (asynchronous, `rst_n` low) loads size code 111, pin code 000 and merge mask 0000. While in reset the outputs are `prog_ce_n`=1110, `data_ce_n`=1111, `data_pin_is_ce`=0000, and `psen_n`, `rd_n`, `wr_n` are all 1. The first fetch from address 0 therefore sees code select 0 active.
- R4: With pin code `p`, `data_pin_is_ce[n]` is 1 exactly when p[2]=1 and n <= p[1:0] (100 gives pin 0 only, 111 gives all four). Codes 000 to 011 leave all four pins as general I/O.
- R5: A data access (`acc_data`=1) in bank n drives `data_ce_n[n]` low only if pin n is a select and merge bit n is 0. In every other case the data selects stay high, and a code access never drives a data select low.
- R6: A data access in bank n with merge bit n set drives `prog_ce_n[n]` low instead of the data select. A code select and a data select are never low together.
- R7: `psen_n` goes low for a read on a code access, or for a data read in a merged bank. `rd_n` goes low for any other data read. `wr_n` goes low for a data write. A write strobe on a code access produces no strobe.
- R8: Selects and strobes are registered one cycle after their inputs. A configuration write is taken on a clock edge, shows on `data_pin_is_ce` straight after that edge, and governs the decode of the inputs presented at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 22 | External bus address |
| acc_data | input | 1 | 1 = data-move access, 0 = code fetch or table read |
| rd_stb | input | 1 | Read request for this cycle |
| wr_stb | input | 1 | Write request for this cycle |
| cfg_size_we | input | 1 | Load the bank-size field |
| cfg_size_wdata | input | 3 | New bank-size code |
| cfg_pins_we | input | 1 | Load the pin-assignment field |
| cfg_pins_wdata | input | 3 | New pin-assignment code |
| cfg_merge_we | input | 1 | Load the merge mask |
| cfg_merge_wdata | input | 4 | New merge mask |
| prog_ce_n | output | 4 | Code memory selects, active low |
| data_ce_n | output | 4 | Data memory selects, active low |
| data_pin_is_ce | output | 4 | 1 = pin carries a data select, 0 = general I/O |
| psen_n | output | 1 | Code read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
A wrong size register moves every bank boundary. It shows as the wrong select, or no select, on the first access near a boundary, one cycle after that address is presented. A corrupted pin or merge register shows at once on `data_pin_is_ce`, or on the next data access as a data select appearing on the wrong side of the code/data split, with `psen_n` and `rd_n` swapped. The bench sweeps both edges of every bank for each size code, crosses pin codes with merge masks, and mixes in random traffic. A reference model compares all outputs on every clock.

// File: rtl/xmem_cs_pkg.sv
package xmem_cs_pkg;
   localparam int unsigned ADDR_W    = 22;
   localparam int unsigned NUM_CE    = 4;
   localparam int unsigned CODE_W    = 3;
   localparam int unsigned MIN_SHIFT = 15;

   localparam logic [CODE_W-1:0] SIZE_RST  = 3'b111;
   localparam logic [CODE_W-1:0] PINS_RST  = 3'b000;
   localparam logic [NUM_CE-1:0] MERGE_RST = '0;

   // log2 of the bank size for a size code
   function automatic int unsigned bank_shift(input logic [CODE_W-1:0] code);
      if (code[CODE_W-1])
         return MIN_SHIFT + 2 + int'(code[CODE_W-2:0]);
      return MIN_SHIFT;
   endfunction
endpackage

// File: rtl/xmem_cs_cfg.sv
module xmem_cs_cfg
   import xmem_cs_pkg::*;
#(
   parameter int unsigned N_CE = NUM_CE,
   parameter int unsigned CW   = CODE_W
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          size_we,
   input  logic [CW-1:0] size_wdata,
   input  logic          pins_we,
   input  logic [CW-1:0] pins_wdata,
   input  logic          merge_we,
   input  logic [N_CE-1:0] merge_wdata,
   output logic [CW-1:0] size_q,
   output logic [CW-1:0] pins_q,
   output logic [N_CE-1:0] merge_q
);
   initial begin
      assert (CW >= 2) else $error("code width too small");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         size_q  <= SIZE_RST;
         pins_q  <= PINS_RST;
         merge_q <= MERGE_RST;
      end else begin
         if (size_we)  size_q  <= size_wdata;
         if (pins_we)  pins_q  <= pins_wdata;
         if (merge_we) merge_q <= merge_wdata;
      end
   end

   assert_size_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      size_we |=> size_q == $past(size_wdata));
   assert_merge_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      merge_we |=> merge_q == $past(merge_wdata));
   assert_pins_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !pins_we |=> $stable(pins_q));
endmodule

// File: rtl/xmem_bank_match.sv
module xmem_bank_match
   import xmem_cs_pkg::*;
#(
   parameter int unsigned AW   = ADDR_W,
   parameter int unsigned N_CE = NUM_CE,
   parameter int unsigned CW   = CODE_W
)(
   input  logic [AW-1:0]   addr,
   input  logic [CW-1:0]   size_code,
   output logic [N_CE-1:0] hit
);
   localparam int unsigned MAX_SHIFT = MIN_SHIFT + 2 + (2**(CW-1)) - 1;

   initial begin
      assert (AW >= MAX_SHIFT + $clog2(N_CE))
         else $error("address too narrow for largest bank set");
   end

   logic [AW-1:0] bank_idx;
   assign bank_idx = addr >> bank_shift(size_code);

   for (genvar n = 0; n < N_CE; n++) begin : g_cmp
      assign hit[n] = (bank_idx == AW'(n));
   end
endmodule

// File: rtl/xmem_pin_map.sv
module xmem_pin_map
   import xmem_cs_pkg::*;
#(
   parameter int unsigned N_CE = NUM_CE,
   parameter int unsigned CW   = CODE_W
)(
   input  logic [CW-1:0]   pins_code,
   output logic [N_CE-1:0] pin_is_ce
);
   initial begin
      assert (N_CE == 2**(CW-1)) else $error("pin count must match code range");
   end

   for (genvar n = 0; n < N_CE; n++) begin : g_pin
      assign pin_is_ce[n] = pins_code[CW-1] && (n <= int'(pins_code[CW-2:0]));
   end
endmodule

// File: rtl/xmem_cs_decode.sv
module xmem_cs_decode
   import xmem_cs_pkg::*;
#(
   parameter int unsigned AW   = ADDR_W,
   parameter int unsigned N_CE = NUM_CE,
   parameter int unsigned CW   = CODE_W
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] addr,
   input  logic          acc_data,
   input  logic          rd_stb,
   input  logic          wr_stb,
   input  logic          cfg_size_we,
   input  logic [CW-1:0] cfg_size_wdata,
   input  logic          cfg_pins_we,
   input  logic [CW-1:0] cfg_pins_wdata,
   input  logic          cfg_merge_we,
   input  logic [N_CE-1:0] cfg_merge_wdata,
   output logic [N_CE-1:0] prog_ce_n,
   output logic [N_CE-1:0] data_ce_n,
   output logic [N_CE-1:0] data_pin_is_ce,
   output logic          psen_n,
   output logic          rd_n,
   output logic          wr_n
);
   logic [CW-1:0]   size_q, pins_q;
   logic [N_CE-1:0] merge_q, hit;
   logic [N_CE-1:0] prog_sel, data_sel;
   logic            merged_hit;

   xmem_cs_cfg #(.N_CE(N_CE), .CW(CW)) i_cfg (
      .clk(clk), .rst_n(rst_n),
      .size_we(cfg_size_we), .size_wdata(cfg_size_wdata),
      .pins_we(cfg_pins_we), .pins_wdata(cfg_pins_wdata),
      .merge_we(cfg_merge_we), .merge_wdata(cfg_merge_wdata),
      .size_q(size_q), .pins_q(pins_q), .merge_q(merge_q));

   xmem_bank_match #(.AW(AW), .N_CE(N_CE), .CW(CW)) i_match (
      .addr(addr), .size_code(size_q), .hit(hit));

   xmem_pin_map #(.N_CE(N_CE), .CW(CW)) i_pins (
      .pins_code(pins_q), .pin_is_ce(data_pin_is_ce));

   assign merged_hit = |(hit & merge_q);
   assign prog_sel   = acc_data ? (hit & merge_q) : hit;
   assign data_sel   = acc_data ? (hit & ~merge_q & data_pin_is_ce) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prog_ce_n <= {{(N_CE-1){1'b1}}, 1'b0};
         data_ce_n <= '1;
         psen_n    <= 1'b1;
         rd_n      <= 1'b1;
         wr_n      <= 1'b1;
      end else begin
         prog_ce_n <= ~prog_sel;
         data_ce_n <= ~data_sel;
         psen_n    <= ~(rd_stb && (!acc_data || merged_hit));
         rd_n      <= ~(rd_stb && acc_data && !merged_hit);
         wr_n      <= ~(wr_stb && acc_data);
      end
   end

   assert_one_prog_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~prog_ce_n));
   assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((~prog_ce_n) & (~data_ce_n)) == '0);
   assert_pin_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((~data_ce_n) & ~$past(data_pin_is_ce)) == '0);
   assert_code_no_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_data |=> data_ce_n == '1);
   assert_one_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(psen_n == 1'b0 && rd_n == 1'b0));
   assert_write_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n |-> $past(acc_data && wr_stb));
endmodule

// File: tb/test_xmem_cs_decode.sv
module test_xmem_cs_decode;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [21:0] addr = '0;
   logic        acc_data = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0;
   logic        cfg_size_we = 1'b0, cfg_pins_we = 1'b0, cfg_merge_we = 1'b0;
   logic [2:0]  cfg_size_wdata = '0, cfg_pins_wdata = '0;
   logic [3:0]  cfg_merge_wdata = '0;
   logic [3:0]  prog_ce_n, data_ce_n, data_pin_is_ce;
   logic        psen_n, rd_n, wr_n;

   always #2 clk = ~clk;

   xmem_cs_decode i_xmem_cs_decode (
      .clk(clk), .rst_n(rst_n), .addr(addr), .acc_data(acc_data),
      .rd_stb(rd_stb), .wr_stb(wr_stb),
      .cfg_size_we(cfg_size_we), .cfg_size_wdata(cfg_size_wdata),
      .cfg_pins_we(cfg_pins_we), .cfg_pins_wdata(cfg_pins_wdata),
      .cfg_merge_we(cfg_merge_we), .cfg_merge_wdata(cfg_merge_wdata),
      .prog_ce_n(prog_ce_n), .data_ce_n(data_ce_n), .data_pin_is_ce(data_pin_is_ce),
      .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n));

   int vectors = 0, miscompares = 0;
   bit finished = 0;

   // reference model state
   logic [2:0] m_size = 3'b111, m_pins = 3'b000;
   logic [3:0] m_merge = 4'b0000;
   logic [3:0] e_prog, e_data, e_pins;
   logic       e_psen, e_rd, e_wr;
   bit         have_exp = 0;

   function automatic int size_log2(input logic [2:0] c);
      return c[2] ? 17 + int'(c[1:0]) : 15;
   endfunction

   function automatic logic [3:0] pins_of(input logic [2:0] c);
      logic [3:0] r = '0;
      for (int n = 0; n < 4; n++)
         if (c[2] && n <= int'(c[1:0])) r[n] = 1'b1;
      return r;
   endfunction

   task automatic predict();
      longint idx = longint'(addr) >> size_log2(m_size);
      bit hit = (idx < 4);
      bit mh = hit && m_merge[idx[1:0]];
      e_prog = 4'hF; e_data = 4'hF;
      if (hit) begin
         if (!acc_data || mh) e_prog[idx[1:0]] = 1'b0;
         else if (pins_of(m_pins)[idx[1:0]]) e_data[idx[1:0]] = 1'b0;
      end
      e_psen = !(rd_stb && (!acc_data || mh));
      e_rd   = !(rd_stb && acc_data && !mh);
      e_wr   = !(wr_stb && acc_data);
      if (cfg_size_we)  m_size  = cfg_size_wdata;
      if (cfg_pins_we)  m_pins  = cfg_pins_wdata;
      if (cfg_merge_we) m_merge = cfg_merge_wdata;
      e_pins = pins_of(m_pins);
      have_exp = 1;
   endtask

   task automatic compare(input string tag);
      vectors++;
      if (prog_ce_n !== e_prog) begin
         miscompares++;
         $display("FAIL %s R1 R2 R6 prog_ce_n actual=%b expected=%b addr=%h", tag, prog_ce_n, e_prog, addr);
      end
      if (data_ce_n !== e_data) begin
         miscompares++;
         $display("FAIL %s R5 data_ce_n actual=%b expected=%b", tag, data_ce_n, e_data);
      end
      if (data_pin_is_ce !== e_pins) begin
         miscompares++;
         $display("FAIL %s R4 data_pin_is_ce actual=%b expected=%b", tag, data_pin_is_ce, e_pins);
      end
      if ({psen_n, rd_n, wr_n} !== {e_psen, e_rd, e_wr}) begin
         miscompares++;
         $display("FAIL %s R7 psen/rd/wr actual=%b expected=%b", tag, {psen_n, rd_n, wr_n}, {e_psen, e_rd, e_wr});
      end
   endtask

   // one cycle: check last expectation (R8: one-cycle latency), drive, predict
   task automatic step(input logic [21:0] a, input logic ad, input logic r, input logic w, input string tag);
      @(negedge clk);
      if (have_exp) compare(tag);
      addr = a; acc_data = ad; rd_stb = r; wr_stb = w;
      predict();
      cfg_size_we = 0; cfg_pins_we = 0; cfg_merge_we = 0;
   endtask

   task automatic set_cfg(input logic [2:0] s, input logic [2:0] p, input logic [3:0] m);
      @(negedge clk);
      if (have_exp) compare("R8 cfg");
      cfg_size_we = 1; cfg_size_wdata = s;
      cfg_pins_we = 1; cfg_pins_wdata = p;
      cfg_merge_we = 1; cfg_merge_wdata = m;
      addr = '0; acc_data = 0; rd_stb = 0; wr_stb = 0;
      predict();
      @(posedge clk);
      #1 cfg_size_we = 0; cfg_pins_we = 0; cfg_merge_we = 0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      logic [2:0] sizes [6] = '{3'b000, 3'b100, 3'b101, 3'b110, 3'b111, 3'b011};
      repeat (3) @(negedge clk);
      // R3: reset values while in reset
      e_prog = 4'b1110; e_data = 4'hF; e_pins = 4'h0;
      e_psen = 1; e_rd = 1; e_wr = 1;
      compare("R3 reset");
      rst_n = 1'b1;
      predict();   // R3: first fetch from 0 hits code select 0
      step(22'h0, 0, 1, 0, "R3 first fetch");

      // R1 R2: bank boundaries for each size code, code reads
      foreach (sizes[i]) begin
         set_cfg(sizes[i], 3'b111, 4'b0000);
         for (int n = 0; n < 5; n++) begin
            longint base = longint'(n) << size_log2(sizes[i]);
            longint last = base + (longint'(1) << size_log2(sizes[i])) - 1;
            if (base < (longint'(1) << 22)) begin
               step(base[21:0], 0, 1, 0, "R1 R2 lo edge");
               step(last[21:0], 0, 1, 0, "R1 R2 hi edge");
               step(base[21:0], 1, 1, 0, "R5 data rd");
               step(last[21:0], 1, 0, 1, "R5 R7 data wr");
               step(base[21:0], 0, 0, 1, "R7 code wr");
            end
         end
      end

      // R4 R5 R6: pin codes crossed with merge masks
      for (int p = 0; p < 8; p++)
         for (int m = 0; m < 16; m += 5) begin
            set_cfg(3'b000, 3'(p), 4'(m));
            for (int n = 0; n < 4; n++) begin
               step(22'(n * 32'h8000 + 32'h10), 1, 1, 0, "R4 R5 R6 rd");
               step(22'(n * 32'h8000 + 32'h20), 1, 0, 1, "R6 R7 wr");
               step(22'(n * 32'h8000 + 32'h30), 0, 1, 0, "R6 code");
            end
         end

      // random traffic with occasional reconfiguration
      for (int k = 0; k < 3000; k++) begin
         if (($urandom % 50) == 0)
            set_cfg(3'($urandom), 3'($urandom), 4'($urandom));
         else begin
            logic [21:0] a = ($urandom % 2) ? 22'($urandom) : 22'($urandom % 32'h40000);
            step(a, 1'($urandom), 1'($urandom), 1'($urandom), "R1 R5 R7 random");
         end
      end
      step(22'h0, 0, 0, 0, "R8 tail");
      finish_run();
   end
endmodule